// File: doc/BRIEF.md
# Fault Event Interrupt Generator

This block turns fault and error events of an address-translation unit into a single interrupt message. It keeps a five-bit fault status word, a control word with a mask bit and a read-only pending flag, and two programmable words that give the message's write address and data. One status bit mirrors an aggregate input that summarises the fault bits of the recording entries. The other four are sticky bits set by event pulses and cleared by software writing ones.

An event is a new interrupt condition only if every status bit was clear beforehand. A new condition sets the pending flag. While the flag is set and the mask is clear, the block offers one write on a valid/ready message channel. The flag clears when that write is accepted, or without any message when software clears every status bit. Setting the mask, or the channel refusing the write, holds the message back and leaves the flag set.

Registers sit behind a simple port with a 6-bit offset: status at 0x00, control at 0x04, message data at 0x08 and message address at 0x0C. Reads return data one cycle after the offset is presented.

Top module: `fault_evt_irq`

## Requirements
- R1: After reset the control word reads 8000_0000h, the status word reads 0 and `msg_valid` is low.
- R2: In the control word (offset 0x04), bit 31 is the mask and can be read and written. Bit 30 is the pending flag and is read-only. Bits 29:0 read as zero, and writes to bits 30:0 have no effect.
- R3: Status bit 0 (offset 0x00) follows `rec_flt_any` one clock later. Status bit k+1 is set by a pulse on `evt_pulse[k]` (k = 0..3) and stays set. The four pulse inputs stand for: an advanced-log fault written to entry 0, a queue error, an invalid device-TLB completion, and a device-TLB completion timeout. Status bits 31:5 read as zero.
- R4: Writing a 1 to status bits 4:1 clears them. Writing to bit 0 has no effect. A pulse in the same cycle as a clear of that bit leaves the bit set.
- R5: A new condition exists when an event pulse or a rising `rec_flt_any` arrives while all status bits are clear. Only a new condition sets the pending flag, and it does so at the next clock edge.
- R6: While the mask is 1, `msg_valid` stays low.
- R7: When the flag is pending and the mask is 0, `msg_valid` rises at the same edge that sets the flag or clears the mask. `msg_addr` and `msg_data` carry the address and data words, latched as `msg_valid` rises. They then stay stable until the handshake completes.
- R8: An accepted handshake (`msg_valid` and `msg_ready` both high at an edge) clears both the pending flag and `msg_valid` at that edge, so exactly one message is sent per condition.
- R9: Software clearing every status bit while a message is pending clears the flag and withdraws `msg_valid`, and no message is sent.
- R10: Setting the mask again before the handshake completes withdraws `msg_valid`, and the pending flag stays set.
- R11: Events that arrive while any status bit is set produce no further message. This holds even after the first message has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 6 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_ofs | input | 6 | Register read offset |
| reg_rd_data | output | 32 | Registered read data, one cycle after the offset |
| rec_flt_any | input | 1 | Level: some fault recording entry holds a fault |
| evt_pulse | input | 4 | One-cycle event pulses for status bits 4:1 |
| msg_valid | output | 1 | Interrupt message offered |
| msg_ready | input | 1 | Message channel accepts |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The assertions assume that `msg_ready` is the only thing that stalls the channel, and that reset is held for at least one clock before any check. They also assume that `evt_pulse` lasts exactly one cycle. Under that assumption, the checks on payload stability and on the one-beat message need only the channel and the status state. The stimulus drives every input on the falling edge, holds reset for several cycles, and keeps each pulse to a single cycle. It also changes the address word and toggles the mask only at points where a withdrawal is the expected outcome.

// File: rtl/fevt_pkg.sv
package fevt_pkg;
  localparam int OFS_W = 6;
  localparam int REG_W = 32;
  localparam int EVT_N = 4;
  localparam int STS_W = EVT_N + 1;
  localparam int OFS_STS_I   = 0;
  localparam int OFS_CTL_I   = 4;
  localparam int OFS_MDATA_I = 8;
  localparam int OFS_MADDR_I = 12;
endpackage

// File: rtl/fevt_regs.sv
module fevt_regs #(
  parameter int OFS_W = fevt_pkg::OFS_W,
  parameter int REG_W = fevt_pkg::REG_W,
  parameter int STS_W = fevt_pkg::STS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [REG_W-1:0] wr_data,
  input  logic [OFS_W-1:0] rd_ofs,
  input  logic [STS_W-1:0] sts,
  input  logic             pend,
  output logic             mask_q,
  output logic             mask_nxt,
  output logic [REG_W-1:0] maddr_q,
  output logic [REG_W-1:0] mdata_q,
  output logic [REG_W-1:0] rd_data
);
  localparam logic [OFS_W-1:0] O_STS   = OFS_W'(fevt_pkg::OFS_STS_I);
  localparam logic [OFS_W-1:0] O_CTL   = OFS_W'(fevt_pkg::OFS_CTL_I);
  localparam logic [OFS_W-1:0] O_MDATA = OFS_W'(fevt_pkg::OFS_MDATA_I);
  localparam logic [OFS_W-1:0] O_MADDR = OFS_W'(fevt_pkg::OFS_MADDR_I);
  localparam int RSV_CTL = REG_W - 2;
  localparam int RSV_STS = REG_W - STS_W;

  logic [REG_W-1:0] rd_mux;

  // mask next-state is exported so the message stage reacts at the same edge
  always_comb begin
    mask_nxt = mask_q;
    if (wr_en && wr_ofs == O_CTL) mask_nxt = wr_data[REG_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b1;
      maddr_q <= '0;
      mdata_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (wr_en && wr_ofs == O_MADDR) maddr_q <= wr_data;
      if (wr_en && wr_ofs == O_MDATA) mdata_q <= wr_data;
    end
  end

  always_comb begin
    unique case (rd_ofs)
      O_STS:   rd_mux = {{RSV_STS{1'b0}}, sts};
      O_CTL:   rd_mux = {mask_q, pend, {RSV_CTL{1'b0}}};
      O_MDATA: rd_mux = mdata_q;
      O_MADDR: rd_mux = maddr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/fevt_status.sv
module fevt_status #(
  parameter int EVT_N = fevt_pkg::EVT_N,
  parameter int STS_W = EVT_N + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_any,
  input  logic [EVT_N-1:0] evt_pulse,
  input  logic             clr_en,
  input  logic [EVT_N-1:0] clr_bits,
  output logic [STS_W-1:0] sts,
  output logic             sts_nxt_zero,
  output logic             new_cond
);
  logic             rec_q;
  logic [EVT_N-1:0] evt_q;
  logic [EVT_N-1:0] evt_d;

  // one sticky write-one-to-clear bit per event source; set wins over clear
  for (genvar k = 0; k < EVT_N; k++) begin : g_sticky
    always_comb evt_d[k] = evt_pulse[k] | (evt_q[k] & ~(clr_en & clr_bits[k]));
    always_ff @(posedge clk) begin
      if (rst) evt_q[k] <= 1'b0;
      else     evt_q[k] <= evt_d[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= 1'b0;
    else     rec_q <= rec_any;
  end

  assign sts          = {evt_q, rec_q};
  assign sts_nxt_zero = ~(|evt_d) & ~rec_any;
  assign new_cond     = ((|evt_pulse) | (rec_any & ~rec_q)) & ~(|sts);
endmodule

// File: rtl/fevt_msg.sv
module fevt_msg #(
  parameter int REG_W = fevt_pkg::REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             new_cond,
  input  logic             sts_nxt_zero,
  input  logic             mask_nxt,
  input  logic [REG_W-1:0] maddr,
  input  logic [REG_W-1:0] mdata,
  input  logic             msg_ready,
  output logic             pend_q,
  output logic             msg_valid,
  output logic [REG_W-1:0] msg_addr,
  output logic [REG_W-1:0] msg_data
);
  logic fire;
  logic pend_d;
  logic valid_d;

  assign fire = msg_valid & msg_ready;

  always_comb begin
    if (new_cond)                  pend_d = 1'b1;
    else if (fire || sts_nxt_zero) pend_d = 1'b0;
    else                           pend_d = pend_q;
    valid_d = pend_d & ~mask_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend_q    <= pend_d;
      msg_valid <= valid_d;
      // payload tracks the programmed words until offered, then freezes
      if (!msg_valid) begin
        msg_addr <= maddr;
        msg_data <= mdata;
      end
    end
  end
endmodule

// File: rtl/fault_evt_irq.sv
module fault_evt_irq #(
  parameter int OFS_W = fevt_pkg::OFS_W,
  parameter int REG_W = fevt_pkg::REG_W,
  parameter int EVT_N = fevt_pkg::EVT_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [OFS_W-1:0] reg_wr_ofs,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic [OFS_W-1:0] reg_rd_ofs,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             rec_flt_any,
  input  logic [EVT_N-1:0] evt_pulse,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [REG_W-1:0] msg_addr,
  output logic [REG_W-1:0] msg_data
);
  localparam int STS_W = EVT_N + 1;
  localparam logic [OFS_W-1:0] O_STS = OFS_W'(fevt_pkg::OFS_STS_I);

  logic [STS_W-1:0] sts_q;
  logic             sts_nxt_zero;
  logic             new_cond;
  logic             mask_q;
  logic             mask_nxt;
  logic             pend_q;
  logic [REG_W-1:0] maddr_q;
  logic [REG_W-1:0] mdata_q;
  logic             clr_en;

  assign clr_en = reg_wr_en && (reg_wr_ofs == O_STS);

  fevt_status #(.EVT_N(EVT_N), .STS_W(STS_W)) u_status (
    .clk(clk), .rst(rst), .rec_any(rec_flt_any), .evt_pulse(evt_pulse),
    .clr_en(clr_en), .clr_bits(reg_wr_data[STS_W-1:1]),
    .sts(sts_q), .sts_nxt_zero(sts_nxt_zero), .new_cond(new_cond)
  );

  fevt_regs #(.OFS_W(OFS_W), .REG_W(REG_W), .STS_W(STS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_ofs(reg_wr_ofs),
    .wr_data(reg_wr_data), .rd_ofs(reg_rd_ofs), .sts(sts_q), .pend(pend_q),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .maddr_q(maddr_q),
    .mdata_q(mdata_q), .rd_data(reg_rd_data)
  );

  fevt_msg #(.REG_W(REG_W)) u_msg (
    .clk(clk), .rst(rst), .new_cond(new_cond), .sts_nxt_zero(sts_nxt_zero),
    .mask_nxt(mask_nxt), .maddr(maddr_q), .mdata(mdata_q),
    .msg_ready(msg_ready), .pend_q(pend_q), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/fevt_chk.sv
module fevt_chk #(
  parameter int REG_W = 32,
  parameter int STS_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             mask,
  input logic             pend,
  input logic [STS_W-1:0] sts,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [REG_W-1:0] msg_addr,
  input logic [REG_W-1:0] msg_data
);
  a_r6_mask_blocks_msg: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !mask);

  a_r7_valid_needs_pend: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> pend);

  a_r7_payload_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(msg_valid && !msg_ready) && msg_valid) |-> ($stable(msg_addr) && $stable(msg_data)));

  a_r8_single_beat: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  a_r9_pend_needs_status: assert property (@(posedge clk) disable iff (rst)
    pend |-> (sts != '0));

  a_r11_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    ((sts != '0) && !pend) |=> !pend);
endmodule

bind fault_evt_irq fevt_chk #(.REG_W(REG_W), .STS_W(EVT_N + 1)) u_chk (
  .clk(clk), .rst(rst), .mask(mask_q), .pend(pend_q), .sts(sts_q),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/test_fault_evt_irq.sv
module test_fault_evt_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {rec level, evt_pulse[3:0], expected status[4:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0000_00001, 10'b0_0001_00010, 10'b0_0010_00100,
    10'b0_0100_01000, 10'b0_1000_10000, 10'b1_1010_10101
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_wr_ofs = '0;
  logic [31:0] reg_wr_data = '0;
  logic [5:0]  reg_rd_ofs = '0;
  logic [31:0] reg_rd_data;
  logic        rec_flt_any = 1'b0;
  logic [3:0]  evt_pulse = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [31:0] msg_data;

  int n_run = 0, n_fail = 0, n_msg = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_evt_irq i_fault_evt_irq (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_ofs(reg_wr_ofs),
    .reg_wr_data(reg_wr_data), .reg_rd_ofs(reg_rd_ofs), .reg_rd_data(reg_rd_data),
    .rec_flt_any(rec_flt_any), .evt_pulse(evt_pulse), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always @(posedge clk) if (!rst && msg_valid && msg_ready) n_msg++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] ofs, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_ofs = ofs; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] ofs, output logic [31:0] d);
    @(negedge clk); reg_rd_ofs = ofs;
    @(negedge clk); d = reg_rd_data;
  endtask

  task automatic pulse(logic [3:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base, bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h04, v); check("R1 ctl reset", v, 32'h8000_0000);
    rd(6'h00, v); check("R1 status reset", v, 32'h0);
    check("R1 valid reset", {31'b0, msg_valid}, 32'h0);
    // R2 reserved and pending bits ignore writes
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check("R2 ctl write ones", v, 32'h8000_0000);
    wr(6'h04, 32'h0);         rd(6'h04, v); check("R2 mask clears", v, 32'h0);
    wr(6'h04, 32'h8000_0000);
    wr(6'h0C, 32'hFEE0_1000); wr(6'h08, 32'h0000_0041);
    rd(6'h0C, v); check("R7 addr word", v, 32'hFEE0_1000);

    // table walk: every source with mask set
    foreach (VEC[i]) begin
      @(negedge clk); rec_flt_any = VEC[i][9]; evt_pulse = VEC[i][8:5];
      @(negedge clk); evt_pulse = '0;
      check($sformatf("R6 masked valid vec%0d", i), {31'b0, msg_valid}, 32'h0);
      rd(6'h00, v); check($sformatf("R3 status vec%0d", i), v, {27'b0, VEC[i][4:0]});
      rd(6'h04, v); check($sformatf("R5 pend vec%0d", i), v, 32'hC000_0000);
      rec_flt_any = 1'b0;
      wr(6'h00, 32'h1F);
      rd(6'h00, v); check($sformatf("R4 cleared vec%0d", i), v, 32'h0);
      rd(6'h04, v); check($sformatf("R9 pend off vec%0d", i), v, 32'h8000_0000);
    end

    // R4 selective clear and set-wins
    pulse(4'b0011);
    wr(6'h00, 32'h04); rd(6'h00, v); check("R4 clear bit2 only", v, 32'h02);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_ofs = 6'h00; reg_wr_data = 32'h02; evt_pulse = 4'b0001;
    @(negedge clk); reg_wr_en = 1'b0; evt_pulse = '0;
    rd(6'h00, v); check("R4 set wins over clear", v, 32'h02);
    wr(6'h00, 32'h1E);

    // R7/R8/R11: long stall then one message
    wr(6'h04, 32'h0);
    base = n_msg;
    pulse(4'b0001);
    check("R7 valid rises", {31'b0, msg_valid}, 32'h1);
    check("R7 addr", msg_addr, 32'hFEE0_1000);
    check("R7 data", msg_data, 32'h0000_0041);
    wr(6'h0C, 32'h1234_5678);
    pulse(4'b0010);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!msg_valid || msg_addr !== 32'hFEE0_1000) bad++;
    end
    check("R7 held during stall", bad, 0);
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    check("R8 one message", n_msg - base, 1);
    check("R8 valid drops", {31'b0, msg_valid}, 32'h0);
    rd(6'h04, v); check("R8 pend cleared", v, 32'h0);
    msg_ready = 1'b1;
    pulse(4'b0100);
    repeat (20) @(negedge clk);
    check("R11 no duplicate", n_msg - base, 1);
    msg_ready = 1'b0;

    // R10 re-mask withdraws valid, pending kept
    wr(6'h00, 32'h1E);
    rd(6'h00, v); check("R4 all clear", v, 32'h0);
    pulse(4'b0001);
    check("R10 valid up", {31'b0, msg_valid}, 32'h1);
    wr(6'h04, 32'h8000_0000);
    check("R10 valid withdrawn", {31'b0, msg_valid}, 32'h0);
    rd(6'h04, v); check("R10 pend kept", v, 32'hC000_0000);
    wr(6'h04, 32'h0);
    check("R10 valid back", {31'b0, msg_valid}, 32'h1);
    check("R7 new addr latched", msg_addr, 32'h1234_5678);
    base = n_msg;
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
    check("R10 single message after unmask", n_msg - base, 1);

    // R9 software service while pending
    wr(6'h00, 32'h1E);
    pulse(4'b1000);
    check("R9 valid up", {31'b0, msg_valid}, 32'h1);
    wr(6'h00, 32'h1E);
    check("R9 valid withdrawn", {31'b0, msg_valid}, 32'h0);
    rd(6'h04, v); check("R9 pend cleared", v, 32'h0);
    base = n_msg; msg_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 no message", n_msg - base, 0);
    msg_ready = 1'b0;

    // R5/R3 via aggregate input; R4 bit0 ignores writes
    wr(6'h04, 32'h8000_0000);
    @(negedge clk); rec_flt_any = 1'b1;
    @(negedge clk);
    rd(6'h04, v); check("R5 rec rise pend", v, 32'hC000_0000);
    wr(6'h00, 32'h01);
    rd(6'h00, v); check("R4 bit0 write ignored", v, 32'h01);
    rec_flt_any = 1'b0;
    repeat (2) @(negedge clk);
    rd(6'h04, v); check("R9 rec fall clears pend", v, 32'h8000_0000);

    finish_run();
  end
endmodule